// File: doc/BRIEF.md
# Byte-Parallel FPGA Configuration Loader

This block loads a downstream SRAM-based FPGA through its slave byte-parallel configuration port. The bitstream is read straight from a byte-wide flash or ROM, so no processor and no separate glue device is needed. A one-cycle start request carries a base address. The loader then runs the reset handshake with the target. It sends a run of 0xFF filler bytes, then walks a binary address counter through the stored bitstream, then sends a run of 0x00 filler bytes. After that it waits for the target to report success or failure.

Each byte is shown to the target on the data bus. The configuration clock is driven low for one cycle and then high again, and the target captures the byte on the rising edge. The target's data pin 0 carries the most significant bit of each byte, so every flash byte is bit-reversed on its way out. Every wait on the target has a cycle-count timeout. When a timeout expires, the loader raises its error flag and goes back to idle. The status pins and the done input are assumed to be already synchronous to `clk`.

Top module: `cfgld_top`

## Requirements
- R1: Out of reset the loader is idle: program, chip-select, write and configuration clock outputs are high (inactive), and busy, ok and err are low.
- R2: A start request seen while idle drives the program output low and raises busy on the next clock edge, and clears ok and err. In closed-loop mode (OPEN_LOOP=0) program is released on the clock edge that first samples init low.
- R3: In open-loop mode (OPEN_LOOP=1) the init pin is not watched while program is low, and program stays low for exactly PROG_HOLD_CYC cycles.
- R4: After program is released, no chip-select and no configuration clock activity occurs until init is sampled high.
- R5: Chip-select and write go low together once at the start of the data phase and stay low for the whole of it. This is 4*PAD_LEN + STREAM_LEN*(ACC_WAIT+3) cycles. Both return high afterwards.
- R6: Each byte is strobed by the configuration clock being low for exactly one cycle and then high. The data bus changes only when the clock falls, so it is stable across every rising edge.
- R7: PAD_LEN bytes of 0xFF are strobed before the bitstream, and PAD_LEN bytes of 0x00 after it.
- R8: The bitstream bytes are read from flash addresses base, base+1, … base+STREAM_LEN-1 in that order. Each is placed bit-reversed on the bus: bus bit i carries flash bit 7-i.
- R9: Each flash byte is sampled only after its address has been stable for ACC_WAIT+1 cycles.
- R10: After the data phase, done sampled high ends the run with ok=1 and err=0. Init sampled low ends it with err=1 and ok=0.
- R11: Each wait (init falling, init rising, end of run) times out after TMO_CYC cycles. The timeout sets err, clears busy, and leaves program, chip-select and the clock high. A timeout while waiting for init to fall keeps busy high for exactly TMO_CYC cycles.
- R12: A start request while busy is ignored: the run in progress continues with its original base address and no new reset pulse is issued.
- R13: ok and err hold their value while idle, whatever the target pins do, until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle start request |
| base_addr_i | input | ADDR_W | First flash address of the bitstream, taken with start |
| busy_o | output | 1 | A load is in progress |
| ok_o | output | 1 | Last load completed with done high |
| err_o | output | 1 | Last load failed (init low or timeout) |
| flash_addr_o | output | ADDR_W | Flash byte address |
| flash_data_i | input | 8 | Flash read data |
| cfg_prog_n_o | output | 1 | Target program/reset request, active low |
| cfg_init_n_i | input | 1 | Target init status, low while clearing or on error |
| cfg_done_i | input | 1 | Target done status |
| cfg_cs_n_o | output | 1 | Target chip-select, active low |
| cfg_wr_n_o | output | 1 | Target write enable, active low |
| cfg_cclk_o | output | 1 | Target configuration clock, rests high |
| cfg_data_o | output | 8 | Target configuration data, bit-reversed flash byte |

## Verification
The hardest situations to reach are the two later timeouts: a target that clears but never raises init, and one that takes the whole bitstream and then reports nothing. The bench target model has knobs that withhold each answer separately, so each wait can expire on its own. Reading flash data too early is also hard to see at the ports. The flash model therefore returns the inverted byte until an address has been stable for more than ACC_WAIT cycles, so an early sample shows up as wrong bus data. Random runs vary the base address, the target's response delays and the outcome, and some of them insert a second start request partway through a run.

// File: rtl/cfgld_pkg.sv
// Shared types and constants of the configuration loader.
package cfgld_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,     // waiting for a start request
        ST_PROG,     // program held low
        ST_INIT_HI,  // program released, waiting for init high
        ST_FETCH,    // flash address applied, waiting for access time
        ST_LOW,      // byte on bus, configuration clock low
        ST_HIGH,     // configuration clock high, byte still held
        ST_END       // data phase over, waiting for done or init
    } ld_state_t;

    typedef enum logic [1:0] {
        PH_PRE,      // leading filler bytes
        PH_BODY,     // bitstream bytes from flash
        PH_POST      // trailing filler bytes
    } ld_phase_t;

    localparam logic [7:0] PAD_HEAD = 8'hFF;
    localparam logic [7:0] PAD_TAIL = 8'h00;

endpackage

// File: rtl/cfgld_wait_timer.sv
// Saturating cycle counter that measures time spent in the current state.
// Assumes the owner pulses clr_i on every state change.
module cfgld_wait_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    output logic [W-1:0] cnt_o
);

    // count up from zero after each clear, stop at all-ones
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_o <= '0;
        else if (clr_i)          cnt_o <= '0;
        else if (cnt_o != '1)    cnt_o <= cnt_o + W'(1);
    end

endmodule

// File: rtl/cfgld_addr_ctr.sv
// Binary flash address counter: loads a base address, then steps by one.
// Assumes load_i and inc_i are never high in the same cycle.
module cfgld_addr_ctr #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] base_i,
    input  logic         inc_i,
    output logic [W-1:0] addr_o
);

    // hold, load or increment the address
    always_ff @(posedge clk) begin
        if (!rst_n)      addr_o <= '0;
        else if (load_i) addr_o <= base_i;
        else if (inc_i)  addr_o <= addr_o + W'(1);
    end

endmodule

// File: rtl/cfgld_bit_flip.sv
// Reverses bit order of a bus: out[i] = in[W-1-i]. Pure wiring.
module cfgld_bit_flip #(
    parameter int W = 8
) (
    input  logic [W-1:0] in_i,
    output logic [W-1:0] out_o
);

    for (genvar i = 0; i < W; i++) begin : g_flip
        assign out_o[i] = in_i[W-1-i];
    end

endmodule

// File: rtl/cfgld_top.sv
// Byte-parallel configuration loader for an SRAM-based FPGA.
// Runs the program/init reset handshake, strobes PAD_LEN 0xFF bytes, the
// STREAM_LEN flash bytes (bit-reversed) and PAD_LEN 0x00 bytes, then waits
// for done or init. Every wait on the target is bounded by TMO_CYC cycles.
// Assumes cfg_init_n_i and cfg_done_i are synchronous to clk, and that
// PROG_HOLD_CYC and TMO_CYC are at least 1.
module cfgld_top
    import cfgld_pkg::*;
#(
    parameter int ADDR_W        = 24,
    parameter int STREAM_LEN    = 69900,
    parameter int PAD_LEN       = 64,
    parameter int PROG_HOLD_CYC = 60,
    parameter int ACC_WAIT      = 2,
    parameter int TMO_CYC       = 200000,
    parameter int OPEN_LOOP     = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] base_addr_i,
    output logic              busy_o,
    output logic              ok_o,
    output logic              err_o,
    output logic [ADDR_W-1:0] flash_addr_o,
    input  logic [7:0]        flash_data_i,
    output logic              cfg_prog_n_o,
    input  logic              cfg_init_n_i,
    input  logic              cfg_done_i,
    output logic              cfg_cs_n_o,
    output logic              cfg_wr_n_o,
    output logic              cfg_cclk_o,
    output logic [7:0]        cfg_data_o
);

    localparam int BYTE_MAX = (STREAM_LEN > PAD_LEN) ? STREAM_LEN : PAD_LEN;
    localparam int CNT_W    = $clog2(BYTE_MAX + 1);
    localparam int T_A      = (TMO_CYC > PROG_HOLD_CYC) ? TMO_CYC : PROG_HOLD_CYC;
    localparam int TMR_MAX  = (T_A > ACC_WAIT + 1) ? T_A : ACC_WAIT + 1;
    localparam int TMR_W    = $clog2(TMR_MAX + 1);

    localparam logic [TMR_W-1:0] TMO_LAST  = TMR_W'(TMO_CYC - 1);
    localparam logic [TMR_W-1:0] HOLD_LAST = TMR_W'(PROG_HOLD_CYC - 1);
    localparam logic [TMR_W-1:0] ACC_LAST  = TMR_W'(ACC_WAIT);
    localparam logic [CNT_W-1:0] PAD_LAST  = CNT_W'(PAD_LEN - 1);
    localparam logic [CNT_W-1:0] BODY_LAST = CNT_W'(STREAM_LEN - 1);

    ld_state_t        state_q, state_d;
    ld_phase_t        phase_q, phase_d;
    logic [CNT_W-1:0] byte_q, byte_d;
    logic [7:0]       data_q, data_d;
    logic [TMR_W-1:0] tmr_cnt;
    logic [7:0]       flash_flip;
    logic [CNT_W-1:0] phase_last;
    logic             addr_ld, addr_inc, fin_ok, fin_err, accept;
    logic             prog_n_q, strobe_n_q, cclk_q, busy_q, ok_q, err_q;

    cfgld_wait_timer #(.W(TMR_W)) i_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (state_d != state_q),
        .cnt_o (tmr_cnt)
    );

    cfgld_addr_ctr #(.W(ADDR_W)) i_addr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (addr_ld),
        .base_i (base_addr_i),
        .inc_i  (addr_inc),
        .addr_o (flash_addr_o)
    );

    cfgld_bit_flip #(.W(8)) i_flip (
        .in_i  (flash_data_i),
        .out_o (flash_flip)
    );

    assign phase_last = (phase_q == PH_BODY) ? BODY_LAST : PAD_LAST;
    assign accept     = (state_q == ST_IDLE) && start_i;

    // next-state, byte sequencing and completion decisions
    always_comb begin
        state_d  = state_q;
        phase_d  = phase_q;
        byte_d   = byte_q;
        data_d   = data_q;
        addr_ld  = 1'b0;
        addr_inc = 1'b0;
        fin_ok   = 1'b0;
        fin_err  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d = ST_PROG;
                    addr_ld = 1'b1;
                end
            end
            ST_PROG: begin
                if (OPEN_LOOP != 0) begin
                    if (tmr_cnt == HOLD_LAST) state_d = ST_INIT_HI;
                end else if (!cfg_init_n_i) begin
                    state_d = ST_INIT_HI;
                end else if (tmr_cnt == TMO_LAST) begin
                    state_d = ST_IDLE;
                    fin_err = 1'b1;
                end
            end
            ST_INIT_HI: begin
                if (cfg_init_n_i) begin
                    state_d = ST_LOW;
                    phase_d = PH_PRE;
                    byte_d  = '0;
                    data_d  = PAD_HEAD;
                end else if (tmr_cnt == TMO_LAST) begin
                    state_d = ST_IDLE;
                    fin_err = 1'b1;
                end
            end
            ST_FETCH: begin
                if (tmr_cnt == ACC_LAST) begin
                    state_d = ST_LOW;
                    data_d  = flash_flip;
                end
            end
            ST_LOW: state_d = ST_HIGH;
            ST_HIGH: begin
                if (byte_q == phase_last) begin
                    byte_d = '0;
                    unique case (phase_q)
                        PH_PRE: begin
                            phase_d = PH_BODY;
                            state_d = ST_FETCH;
                        end
                        PH_BODY: begin
                            phase_d = PH_POST;
                            state_d = ST_LOW;
                            data_d  = PAD_TAIL;
                        end
                        default: state_d = ST_END;
                    endcase
                end else begin
                    byte_d = byte_q + CNT_W'(1);
                    if (phase_q == PH_BODY) begin
                        state_d  = ST_FETCH;
                        addr_inc = 1'b1;
                    end else begin
                        state_d = ST_LOW;
                    end
                end
            end
            ST_END: begin
                if (cfg_done_i) begin
                    state_d = ST_IDLE;
                    fin_ok  = 1'b1;
                end else if (!cfg_init_n_i || tmr_cnt == TMO_LAST) begin
                    state_d = ST_IDLE;
                    fin_err = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // sequencer state registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            phase_q <= PH_PRE;
            byte_q  <= '0;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            phase_q <= phase_d;
            byte_q  <= byte_d;
            data_q  <= data_d;
        end
    end

    // target pin drivers, registered from the next state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prog_n_q   <= 1'b1;
            strobe_n_q <= 1'b1;
            cclk_q     <= 1'b1;
            busy_q     <= 1'b0;
        end else begin
            prog_n_q   <= (state_d != ST_PROG);
            strobe_n_q <= !(state_d inside {ST_FETCH, ST_LOW, ST_HIGH});
            cclk_q     <= (state_d != ST_LOW);
            busy_q     <= (state_d != ST_IDLE);
        end
    end

    // completion status, cleared by an accepted start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ok_q  <= 1'b0;
            err_q <= 1'b0;
        end else begin
            if (accept) begin
                ok_q  <= 1'b0;
                err_q <= 1'b0;
            end
            if (fin_ok)  ok_q  <= 1'b1;
            if (fin_err) err_q <= 1'b1;
        end
    end

    assign cfg_prog_n_o = prog_n_q;
    assign cfg_cs_n_o   = strobe_n_q;
    assign cfg_wr_n_o   = strobe_n_q;
    assign cfg_cclk_o   = cclk_q;
    assign cfg_data_o   = data_q;
    assign busy_o       = busy_q;
    assign ok_o         = ok_q;
    assign err_o        = err_q;

endmodule

// File: rtl/cfgld_checker.sv
// Protocol checker for cfgld_top, attached by bind. Observes ports only.
module cfgld_checker #(
    parameter int OPEN_LOOP = 0
) (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       busy_o,
    input logic       ok_o,
    input logic       err_o,
    input logic       cfg_prog_n_o,
    input logic       cfg_init_n_i,
    input logic       cfg_cs_n_o,
    input logic       cfg_cclk_o,
    input logic [7:0] cfg_data_o
);

    // R2: closed loop releases program right after init is seen low
    a_r2_prog_release: assert property (@(posedge clk) disable iff (!rst_n)
        (OPEN_LOOP == 0 && !cfg_prog_n_o && !cfg_init_n_i) |=> cfg_prog_n_o);

    // R4: data phase opens only after init was sampled high
    a_r4_cs_after_init: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cfg_cs_n_o) |-> $past(cfg_init_n_i));

    // R5: chip-select never overlaps the program pulse
    a_r5_cs_not_in_prog: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_cs_n_o |-> cfg_prog_n_o);

    // R6: clock low only inside the data phase, for one cycle
    a_r6_clk_in_phase: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_cclk_o |-> !cfg_cs_n_o);
    a_r6_clk_low_one: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_cclk_o |=> cfg_cclk_o);
    a_r6_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_cclk_o) |-> $stable(cfg_data_o));

    // R10: never both results at once
    a_r10_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(ok_o && err_o));

    // R13: status held while idle without start; cleared while busy
    a_r13_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable({ok_o, err_o}));
    a_r13_clear_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !(ok_o || err_o));

endmodule

bind cfgld_top cfgld_checker #(.OPEN_LOOP(OPEN_LOOP)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .busy_o       (busy_o),
    .ok_o         (ok_o),
    .err_o        (err_o),
    .cfg_prog_n_o (cfg_prog_n_o),
    .cfg_init_n_i (cfg_init_n_i),
    .cfg_cs_n_o   (cfg_cs_n_o),
    .cfg_cclk_o   (cfg_cclk_o),
    .cfg_data_o   (cfg_data_o)
);

// File: tb/test_cfgld_top.sv
`timescale 1ns/1ps
module test_cfgld_top;

    localparam int AW   = 16;
    localparam int LEN  = 40;
    localparam int PAD  = 64;
    localparam int HOLD = 60;
    localparam int ACC  = 3;
    localparam int TMO  = 400;
    localparam int NBYT = 2 * PAD + LEN;
    localparam int DCYC = 4 * PAD + LEN * (ACC + 3);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;   // 200 MHz

    // closed-loop instance signals
    logic          start = 1'b0, busy, ok, err;
    logic [AW-1:0] base = '0, faddr;
    logic [7:0]    fdata = '0, cdata;
    logic          prog_n, init_n = 1'b1, done = 1'b0, cs_n, wr_n, cclk;

    // open-loop instance signals
    logic          start2 = 1'b0, busy2, ok2, err2;
    logic [AW-1:0] faddr2;
    logic [7:0]    fdata2, cdata2;
    logic          prog2_n, done2 = 1'b0, cs2_n, wr2_n, cclk2;

    cfgld_top #(.ADDR_W(AW), .STREAM_LEN(LEN), .PAD_LEN(PAD), .PROG_HOLD_CYC(HOLD),
                .ACC_WAIT(ACC), .TMO_CYC(TMO), .OPEN_LOOP(0)) i_cfgld_top (
        .clk(clk), .rst_n(rst_n), .start_i(start), .base_addr_i(base),
        .busy_o(busy), .ok_o(ok), .err_o(err), .flash_addr_o(faddr), .flash_data_i(fdata),
        .cfg_prog_n_o(prog_n), .cfg_init_n_i(init_n), .cfg_done_i(done),
        .cfg_cs_n_o(cs_n), .cfg_wr_n_o(wr_n), .cfg_cclk_o(cclk), .cfg_data_o(cdata));

    cfgld_top #(.ADDR_W(AW), .STREAM_LEN(LEN), .PAD_LEN(PAD), .PROG_HOLD_CYC(HOLD),
                .ACC_WAIT(ACC), .TMO_CYC(TMO), .OPEN_LOOP(1)) i_cfgld_top_ol (
        .clk(clk), .rst_n(rst_n), .start_i(start2), .base_addr_i(base),
        .busy_o(busy2), .ok_o(ok2), .err_o(err2), .flash_addr_o(faddr2), .flash_data_i(fdata2),
        .cfg_prog_n_o(prog2_n), .cfg_init_n_i(1'b1), .cfg_done_i(done2),
        .cfg_cs_n_o(cs2_n), .cfg_wr_n_o(wr2_n), .cfg_cclk_o(cclk2), .cfg_data_o(cdata2));

    int n_tests = 0, n_fail = 0;
    bit finished = 1'b0;

    function automatic logic [7:0] flash_fn(input logic [AW-1:0] a);
        return (a[7:0] * 8'd29) ^ a[15:8] ^ 8'h5A;
    endfunction

    function automatic logic [7:0] rev8(input logic [7:0] v);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = v[7-i];
        return r;
    endfunction

    function automatic logic [7:0] exp_byte(input int i, input logic [AW-1:0] b);
        if (i < PAD) return 8'hFF;
        if (i < PAD + LEN) return rev8(flash_fn(b + AW'(i - PAD)));
        return 8'h00;
    endfunction

    assign fdata2 = flash_fn(faddr2);

    // target model knobs and monitor results
    bit  ans_lo, ans_hi;
    int  lo_dly, hi_dly, emode, edly;
    int  t_lo, t_hi, t_end;
    bit  t_rst, t_arm;
    logic [AW-1:0] last_addr = '0;
    int  age = 0;
    logic prev_cs = 1'b1, prev_ck = 1'b1, prev2_cs = 1'b1;
    logic [7:0] prev_d = '0;
    int  both_lo, cs_fall, cs_lo, wr_lo, cs_init_lo, viol, busy_cyc, prog_lo, ncap, prog_fall, prog2_lo;
    logic prev_prog = 1'b1;
    logic [7:0] cap [0:255];

    // target, flash model and monitors; updated at the falling clock edge
    always @(negedge clk) begin
        // target reset handshake
        if (!prog_n) begin
            done = 1'b0; t_hi = 0;
            if (ans_lo && t_lo >= lo_dly) begin init_n = 1'b0; t_rst = 1'b1; end
            t_lo++;
        end else begin
            t_lo = 0;
            if (t_rst) begin
                if (ans_hi && t_hi >= hi_dly) begin init_n = 1'b1; t_rst = 1'b0; end
                t_hi++;
            end
        end
        // target end-of-run answer
        if (!prev_cs && cs_n) begin t_arm = 1'b1; t_end = 0; end
        if (t_arm) begin
            if (t_end >= edly) begin
                if (emode == 0) done = 1'b1;
                else if (emode == 1) init_n = 1'b0;
                t_arm = 1'b0;
            end
            t_end++;
        end
        // flash model: inverted data until address has aged past ACC
        if (faddr != last_addr) begin last_addr = faddr; age = 1; end
        else if (age < 1000) age++;
        fdata = (age > ACC) ? flash_fn(last_addr) : ~flash_fn(last_addr);
        // monitors
        if (!prog_n && !init_n) both_lo++;
        if (!prog_n) prog_lo++;
        if (prev_prog && !prog_n) prog_fall++;
        if (prev_cs && !cs_n) cs_fall++;
        if (!cs_n) cs_lo++;
        if (!wr_n) wr_lo++;
        if (!cs_n && !init_n) cs_init_lo++;
        if (busy) busy_cyc++;
        if (!prev_ck && !cclk) viol++;
        if (cclk && cdata != prev_d) viol++;
        if (!prev_ck && cclk && !cs_n) begin
            if (ncap < 256) cap[ncap] = cdata;
            ncap++;
        end
        if (!prog2_n) prog2_lo++;
        if (!prev2_cs && cs2_n) done2 = 1'b1;
        if (!prog2_n) done2 = 1'b0;
        prev_cs = cs_n; prev_ck = cclk; prev_d = cdata; prev_prog = prog_n; prev2_cs = cs2_n;
    end

    task automatic chk(input bit good, input string req, input string what,
                       input longint act, input longint exp);
        n_tests++;
        if (!good) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // one closed-loop run; target knobs set, monitors cleared, start pulsed
    task automatic run_one(input logic [AW-1:0] b, input bit alo, input bit ahi,
                           input int ld, input int hd, input int em, input int ed,
                           input int xs_at);
        @(posedge clk); #1;
        ans_lo = alo; ans_hi = ahi; lo_dly = ld; hi_dly = hd; emode = em; edly = ed;
        t_lo = 0; t_hi = 0; t_end = 0; t_rst = 1'b0; t_arm = 1'b0;
        init_n = 1'b1; done = 1'b0;
        both_lo = 0; cs_fall = 0; cs_lo = 0; wr_lo = 0; cs_init_lo = 0; viol = 0;
        busy_cyc = 0; prog_lo = 0; ncap = 0; prog_fall = 0;
        @(negedge clk); base = b; start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk(busy && !ok && !err && !prog_n, "R2", "start raises busy, clears status, program low",
            {busy, ok, err, prog_n}, 4'b1000);
        for (int c = 0; c < 20000; c++) begin
            @(negedge clk);
            if (c == xs_at) begin base = b ^ 16'h1234; start = 1'b1; end
            else start = 1'b0;
            if (!busy) break;
        end
        start = 1'b0;
    endtask

    // checks common to a run that reached the end of the data phase
    task automatic chk_data_run(input logic [AW-1:0] b);
        int bad = 0, first = -1;
        chk(both_lo == 1, "R2", "cycles with program and init both low", both_lo, 1);
        chk(cs_init_lo == 0, "R4", "chip-select low while init low", cs_init_lo, 0);
        chk(cs_fall == 1 && cs_lo == DCYC && wr_lo == DCYC, "R5", "data phase length",
            cs_lo, DCYC);
        chk(cs_n && wr_n && cclk && prog_n, "R5", "pins released after run",
            {cs_n, wr_n, cclk, prog_n}, 4'b1111);
        chk(viol == 0, "R6", "clock/data strobe violations", viol, 0);
        chk(ncap == NBYT, "R7", "bytes strobed", ncap, NBYT);
        for (int i = 0; i < NBYT && i < ncap; i++)
            if (cap[i] != exp_byte(i, b)) begin bad++; if (first < 0) first = i; end
        chk(bad == 0, "R8", "bitstream byte mismatches (R7 pads, R9 access wait)",
            (first < 0) ? 0 : cap[first], (first < 0) ? 0 : exp_byte(first, b));
    endtask

    initial begin
        logic [AW-1:0] rb;
        int r;
        r = $urandom(32'd7341);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(prog_n && cs_n && wr_n && cclk && !busy && !ok && !err, "R1", "reset state",
            {prog_n, cs_n, wr_n, cclk, busy, ok, err}, 7'b1111000);

        // directed successful run
        run_one(16'h0100, 1, 1, 5, 7, 0, 10, -1);
        chk_data_run(16'h0100);
        chk(ok && !err, "R10", "ok after done", {ok, err}, 2'b10);
        // R13: status holds while target pins wander
        repeat (5) @(negedge clk);
        done = 1'b0; init_n = 1'b0;
        repeat (5) @(negedge clk);
        chk(ok && !err && !busy, "R13", "ok held while idle", {ok, err, busy}, 3'b100);
        init_n = 1'b1;

        // init low after data phase
        run_one(16'hFFF0, 1, 1, 2, 3, 1, 4, -1);
        chk_data_run(16'hFFF0);
        chk(!ok && err, "R10", "err after init low", {ok, err}, 2'b01);

        // timeout waiting for init to fall
        run_one(16'h0200, 0, 1, 0, 0, 0, 0, -1);
        chk(err && !ok && prog_n && cs_n, "R11", "init-fall timeout", {err, ok, prog_n, cs_n}, 4'b1011);
        chk(busy_cyc == TMO && prog_lo == TMO, "R11", "init-fall timeout length", busy_cyc, TMO);
        chk(ncap == 0, "R11", "no bytes after init-fall timeout", ncap, 0);

        // timeout waiting for init to rise
        run_one(16'h0300, 1, 0, 3, 0, 0, 0, -1);
        chk(err && !ok && ncap == 0 && cs_n && prog_n, "R4", "no data while init stays low (R11)",
            ncap, 0);

        // timeout waiting for done
        run_one(16'h0400, 1, 1, 1, 1, 2, 0, -1);
        chk(err && !ok && cs_n && prog_n && cclk, "R11", "end-of-run timeout", {err, ok}, 2'b10);

        // start while busy is ignored
        run_one(16'h0500, 1, 1, 4, 4, 0, 6, 150);
        chk_data_run(16'h0500);
        chk(prog_fall == 1 && ok, "R12", "second start ignored", prog_fall, 1);

        // random runs
        for (int k = 0; k < 6; k++) begin
            int em;
            rb = AW'($urandom);
            em = ($urandom % 4 == 0) ? 1 : 0;
            run_one(rb, 1, 1, $urandom % 20, $urandom % 20, em, $urandom % 30,
                    ($urandom % 2) ? int'($urandom % 400) : -1);
            chk_data_run(rb);
            chk(em == 0 ? (ok && !err) : (err && !ok), "R10", "random run result",
                {ok, err}, em == 0 ? 2 : 1);
            chk(prog_fall == 1, "R12", "one reset pulse per run", prog_fall, 1);
        end

        // open-loop instance
        prog2_lo = 0;
        @(negedge clk); start2 = 1'b1;
        @(negedge clk); start2 = 1'b0;
        for (int c = 0; c < 5000 && busy2; c++) @(negedge clk);
        chk(prog2_lo == HOLD, "R3", "open-loop program low cycles", prog2_lo, HOLD);
        chk(ok2 && !err2, "R3", "open-loop run completes", {ok2, err2}, 2'b10);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule